// File: doc/BRIEF.md
# Speculative Store Buffer with Rollback

This block sits between a speculative datapath and the word array it updates. Writes from the datapath do not reach the array at once: they enter a short shift-register queue of pending address/data entries, newest at the head. Each read address is compared against every pending entry in the same cycle. The data of the newest matching entry is returned ahead of the array contents, so the datapath always sees the latest speculative state.

When the datapath learns that some recent writes were made on a wrong guess, it requests a rollback by a count d. The d newest entries are then marked invalid, so they are neither forwarded nor written to the array. The queue advances by one slot on every write and every commit. An entry that leaves the oldest slot while still valid is written into the array. The queue depth is the longest rollback the block can undo, and it is kept small because every slot carries its own comparator.

Top module: `spec_store_buf`

## Requirements
- R1: A write (wr_en high, rb_en low) enters the newest queue slot. The array is not changed by it until that entry leaves the oldest slot.
- R2: A read address is compared against all valid queue entries at once. On one or more matches, the data of the newest matching entry is returned and rd_fwd is 1.
- R3: When no valid entry matches, the read is served from the array and rd_fwd is 0.
- R4: A read presented in one cycle returns rd_data and rd_fwd after the next clock edge, with rd_valid high for exactly that cycle. The read sees the queue and the array as they stood before any write, rollback or commit in its own cycle.
- R5: The queue advances by exactly one slot in any cycle with a write, a commit, or both. An entry pushed out of the oldest slot is written to the array only if it is still valid. With no write, commit or rollback, the queue is unchanged.
- R6: A rollback by d clears the valid bits of the d newest slots. A d of DEPTH or more clears every slot, and d = 0 has no effect. Cleared entries are never forwarded and never written to the array.
- R7: In a rollback cycle, any write is dropped. A commit in the same cycle still advances the queue, after the invalidation has been applied.
- R8: After reset the queue is empty, every array word reads 0, and rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Speculative write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result valid (one cycle after rd_en) |
| rd_data | output | DATA_W | Read result |
| rd_fwd | output | 1 | 1 = result forwarded from the queue, 0 = from the array |
| rb_en | input | 1 | Rollback request |
| rb_count | input | RB_W | Number of newest entries to discard |
| commit | input | 1 | Advance the queue by one slot, retiring the oldest entry |

## Verification
Reads are tried against a queue that holds two writes to the same address, which shows whether the newest or the oldest match is chosen. They are also tried against addresses held only in the array, which separates forwarding from array reads. Rollbacks of 0, 1, 2 and the full depth are applied, and then entries are pushed to the array. Reading the array afterwards shows whether discarded entries leaked into memory and whether surviving ones retired. Same-cycle mixes of write with commit, rollback with write, rollback with commit, and read with write to the same address show that the queue advances by exactly one slot and that the documented priorities hold.

// File: rtl/sb_pkg.sv
// Package: default sizes shared by the store buffer modules.
// Assumes: nothing; holds constants only.
package sb_pkg;
    localparam int SB_ADDR_W = 6;
    localparam int SB_DATA_W = 16;
    localparam int SB_DEPTH  = 4;
endpackage

// File: rtl/sb_mem.sv
// Module: sb_mem
// Word array behind the store buffer: one registered read and one write per cycle.
// Assumes: synchronous active-low reset clears all words (array kept small).
module sb_mem #(
    parameter int ADDR_W = sb_pkg::SB_ADDR_W,
    parameter int DATA_W = sb_pkg::SB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] words [WORDS];

    // Array update: clear on reset, else store a retired entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) words[i] <= '0;
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Registered read port (returns the word as it was before this edge).
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= words[raddr];
    end
endmodule

// File: rtl/sb_queue.sv
// Module: sb_queue
// Shift-register queue of pending writes, slot 0 newest, slot DEPTH-1 oldest.
// Rollback clears valid bits of the newest slots; a write or commit advances
// the queue by one slot and the entry leaving the oldest slot is retired.
// Assumes: a rollback cycle drops any write; commit still advances afterwards.
module sb_queue #(
    parameter int ADDR_W = sb_pkg::SB_ADDR_W,
    parameter int DATA_W = sb_pkg::SB_DATA_W,
    parameter int DEPTH  = sb_pkg::SB_DEPTH,
    parameter int RB_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rb_en,
    input  logic [RB_W-1:0]   rb_count,
    input  logic              commit,
    output logic [DEPTH-1:0]  slot_vld,
    output logic [ADDR_W-1:0] slot_addr [DEPTH],
    output logic [DATA_W-1:0] slot_data [DEPTH],
    output logic              ret_en,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [DATA_W-1:0] ret_data
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] vld_kept;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic take_wr;
    logic advance;

    // Qualify the incoming write and decide whether the queue moves.
    always_comb begin
        take_wr = wr_en && !rb_en;
        advance = take_wr || commit;
    end

    // Per-slot valid after rollback invalidation of the newest rb_count slots.
    for (genvar g = 0; g < DEPTH; g++) begin : g_keep
        always_comb vld_kept[g] = vld_q[g] && !(rb_en && (rb_count > RB_W'(g)));
    end

    // Head slot: loads the new write, or becomes empty when the queue advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0]  <= 1'b0;
            addr_q[0] <= '0;
            data_q[0] <= '0;
        end else if (advance) begin
            vld_q[0]  <= take_wr;
            addr_q[0] <= wr_addr;
            data_q[0] <= wr_data;
        end else begin
            vld_q[0]  <= vld_kept[0];
        end
    end

    // Remaining slots: take the neighbour on advance, else keep own state.
    for (genvar g = 1; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                addr_q[g] <= '0;
                data_q[g] <= '0;
            end else if (advance) begin
                vld_q[g]  <= vld_kept[g-1];
                addr_q[g] <= addr_q[g-1];
                data_q[g] <= data_q[g-1];
            end else begin
                vld_q[g]  <= vld_kept[g];
            end
        end
    end

    // Retirement of the oldest slot when it is pushed out still valid.
    always_comb begin
        ret_en   = advance && vld_kept[LAST];
        ret_addr = addr_q[LAST];
        ret_data = data_q[LAST];
    end

    assign slot_vld  = vld_q;
    assign slot_addr = addr_q;
    assign slot_data = data_q;

    // R1
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rb_en) |=> (vld_q[0] && addr_q[0] == $past(wr_addr)
                               && data_q[0] == $past(wr_data)));
    // R6
    rb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_en && rb_count != '0) |=> !vld_q[0]);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !commit && !rb_en) |=> $stable(vld_q));
endmodule

// File: rtl/sb_match.sv
// Module: sb_match
// Compares one read address against every queue slot in parallel and picks
// the newest valid match (lowest slot index).
// Assumes: slot 0 is the newest entry.
module sb_match #(
    parameter int ADDR_W = sb_pkg::SB_ADDR_W,
    parameter int DATA_W = sb_pkg::SB_DATA_W,
    parameter int DEPTH  = sb_pkg::SB_DEPTH
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DEPTH-1:0]  slot_vld,
    input  logic [ADDR_W-1:0] slot_addr [DEPTH],
    input  logic [DATA_W-1:0] slot_data [DEPTH],
    output logic              hit,
    output logic [DATA_W-1:0] hit_data
);
    logic [DEPTH-1:0] eq;

    // One comparator per slot, all evaluated together.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        always_comb eq[g] = slot_vld[g] && (slot_addr[g] == rd_addr);
    end

    // Priority pick: scanning oldest to newest lets the newest match win.
    always_comb begin
        hit      = |eq;
        hit_data = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) hit_data = slot_data[i];
        end
    end
endmodule

// File: rtl/spec_store_buf.sv
// Module: spec_store_buf (top)
// Speculative store buffer: queues writes, forwards newest pending data to
// reads, discards recent writes on rollback, retires the oldest to the array.
// Assumes: reads see state before same-cycle updates; results one cycle later.
module spec_store_buf #(
    parameter int ADDR_W = sb_pkg::SB_ADDR_W,
    parameter int DATA_W = sb_pkg::SB_DATA_W,
    parameter int DEPTH  = sb_pkg::SB_DEPTH,
    parameter int RB_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fwd,
    input  logic              rb_en,
    input  logic [RB_W-1:0]   rb_count,
    input  logic              commit
);
    logic [DEPTH-1:0]  slot_vld;
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic              ret_en;
    logic [ADDR_W-1:0] ret_addr;
    logic [DATA_W-1:0] ret_data;
    logic              hit;
    logic [DATA_W-1:0] hit_data;
    logic [DATA_W-1:0] mem_rdata;
    logic              hit_q;
    logic [DATA_W-1:0] fwd_q;
    logic              rdv_q;

    sb_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .RB_W(RB_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rb_en(rb_en), .rb_count(rb_count), .commit(commit),
        .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_data(slot_data),
        .ret_en(ret_en), .ret_addr(ret_addr), .ret_data(ret_data)
    );

    sb_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
        .rd_addr(rd_addr), .slot_vld(slot_vld), .slot_addr(slot_addr),
        .slot_data(slot_data), .hit(hit), .hit_data(hit_data)
    );

    sb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(ret_en), .waddr(ret_addr), .wdata(ret_data),
        .re(rd_en), .raddr(rd_addr), .rdata(mem_rdata)
    );

    // Capture the forwarding decision alongside the array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            fwd_q <= '0;
            rdv_q <= 1'b0;
        end else begin
            rdv_q <= rd_en;
            if (rd_en) begin
                hit_q <= hit;
                fwd_q <= hit_data;
            end
        end
    end

    // Final read mux: forwarded queue data overrides the array word.
    always_comb begin
        rd_valid = rdv_q;
        rd_fwd   = hit_q;
        rd_data  = hit_q ? fwd_q : mem_rdata;
    end

    // R4
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R4
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: tb/spec_store_buf_tb.sv
module spec_store_buf_tb;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DP = 4;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_fwd;
    logic          rb_en = 1'b0;
    logic [RW-1:0] rb_count = '0;
    logic          commit = 1'b0;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    spec_store_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP), .RB_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_fwd(rd_fwd),
        .rb_en(rb_en), .rb_count(rb_count), .commit(commit)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of control: drive at negedge, let one edge pass.
    task automatic step(input logic we, input int wa, input int wd,
                        input logic rb, input int rbn, input logic cm);
        wr_en = we; wr_addr = AW'(wa); wr_data = DW'(wd);
        rb_en = rb; rb_count = RW'(rbn); commit = cm;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; rb_en = 1'b0; rb_count = '0; commit = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        step(1'b1, a, d, 1'b0, 0, 1'b0);
    endtask

    // Read and check data/forward flag one edge later.
    task automatic rd(input int a, input int exp_d, input int exp_f, input string req);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        chk({req, " rd_valid"}, int'(rd_valid), 1);
        chk({req, " rd_data"}, int'(rd_data), exp_d);
        chk({req, " rd_fwd"}, int'(rd_fwd), exp_f);
    endtask

    task automatic t_reset();
        chk("R8 rd_valid after reset", int'(rd_valid), 0);
        rd(5, 0, 0, "R8 empty read");
    endtask

    task automatic t_forward();
        wr(5, 11);
        rd(5, 11, 1, "R2 single match");
        wr(5, 22);
        rd(5, 22, 1, "R2 newest of two");
        rd(7, 0, 0, "R3 miss to array");
    endtask

    task automatic t_rollback();
        step(1'b0, 0, 0, 1'b1, 1, 1'b0);
        rd(5, 11, 1, "R6 rollback one");
        wr(9, 33);
        wr(9, 44);
        step(1'b0, 0, 0, 1'b1, 2, 1'b0);
        rd(9, 0, 0, "R6 rollback two");
        rd(5, 11, 1, "R6 older entry kept");
        step(1'b0, 0, 0, 1'b0, 0, 1'b1);
        rd(5, 11, 0, "R5 commit retires");
    endtask

    task automatic t_push_out();
        wr(1, 100); wr(2, 200); wr(3, 300); wr(4, 400);
        rd(1, 100, 1, "R1 held in queue");
        wr(5, 500);
        rd(1, 100, 0, "R5 pushed to array");
        rd(2, 200, 1, "R5 neighbour still queued");
    endtask

    task automatic t_priority();
        step(1'b1, 6, 600, 1'b1, 1, 1'b0);
        rd(6, 0, 0, "R7 write dropped");
        rd(5, 11, 0, "R6 rolled entry not forwarded");
        step(1'b0, 0, 0, 1'b1, 0, 1'b0);
        rd(4, 400, 1, "R6 zero count no effect");
        step(1'b0, 0, 0, 1'b1, 4, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b1);
        rd(2, 0, 0, "R6 full rollback never retires");
        rd(4, 0, 0, "R6 full rollback never retires");
    endtask

    task automatic t_mixed();
        step(1'b1, 8, 800, 1'b0, 0, 1'b1);
        wr(11, 1); wr(12, 2); wr(13, 3);
        rd(8, 800, 1, "R5 write+commit single shift");
        rd_en = 1'b1; rd_addr = AW'(20);
        wr_en = 1'b1; wr_addr = AW'(20); wr_data = DW'(5);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R4 read before same-cycle write", int'(rd_data), 0);
        chk("R4 read before same-cycle write fwd", int'(rd_fwd), 0);
        chk("R4 idle rd_valid", int'(rd_valid), 1);
        @(posedge clk); @(negedge clk);
        chk("R4 rd_valid low without read", int'(rd_valid), 0);
        rd(20, 5, 1, "R1 write visible next cycle");
        rd(8, 800, 0, "R5 retired on write");
        step(1'b0, 0, 0, 1'b1, 1, 1'b1);
        rd(11, 1, 0, "R7 commit after rollback retires");
        rd(20, 0, 0, "R7 rolled head not kept");
        rd(13, 3, 1, "R7 survivors forwarded");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_forward();
        t_rollback();
        t_push_out();
        t_priority();
        t_mixed();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #100000;
        nfail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule